// File: doc/BRIEF.md
# Column-Bypass Array Multiplier

This block multiplies two unsigned WIDTH-bit operands and returns the full 2*WIDTH-bit product. It is built as a carry-save array of adder cells that sums the partial products a_i·b_j in parallel. A ripple-carry merge row then produces the upper half of the result. The cells are grouped by multiplicand bit: every cell on the diagonal fed by bit a_i is enabled by that bit. The design targets datapaths such as filter tap multipliers, where multiplicand words often contain zeros and switching in the adder array is the main power cost.

When a multiplicand bit is zero, all cells in its column are bypassed. The partial product and the carry arriving from the cell above are both zero in that case. Each bypassed cell therefore forces its carry output to zero and passes the sum from the cell above through a 2:1 multiplexer. Its adder inputs are AND-gated with the same bit, so the adder logic does not toggle. The first adder row has no incoming carry and acts as a half adder. A parameter selects an optional output register with a synchronous active-high reset.

Top module: `colbyp_mult`

## Requirements
- R1: P equals the unsigned product A×B over all 2*WIDTH bits. With the output register enabled, P shows the product of the operands sampled at the previous rising clock edge.
- R2: When A is zero, P is zero one clock later, whatever the value of B.
- R3: For every multiplicand bit a_i that is 0, every carry output in column i of the adder array is 0.
- R4: For every multiplicand bit a_i that is 0, each adder cell in column i outputs the sum from the cell above it. For the top column a_(WIDTH-1), that upper sum is 0.
- R5: When rst is high at a rising clock edge, P becomes 0 on that edge and stays 0 for as long as rst is held.
- R6: With the output register enabled, a change on A or B does not reach P before the next rising clock edge.
- R7: All-ones A times all-ones B gives (2^WIDTH-1)^2, with the top product bit set. For WIDTH=4 this is 225.
- R8: With WIDTH=8 the block produces correct 16-bit products, including 255×255 = 65025 and 170×85 = 14450.
- R9: For WIDTH=4, A=4'b1010 with B=4'b1111 bypasses columns 0 and 2 and gives P=150.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | WIDTH | Multiplicand; each bit enables one column of adder cells |
| b | input | WIDTH | Multiplier; each bit selects one row of partial products |
| p | output | 2*WIDTH | Unsigned product |

## Verification
The hardest behaviour to reach is a bypassed column deep in the array whose neighbours are still active. There, the pass-through sum and the forced-zero carry must combine correctly with live carries from the adjacent columns. Only the final product shows this at the ports. The stimulus therefore sweeps every operand pair at WIDTH=4, covering every mix of active and bypassed columns. It adds alternating-bit and sparse multiplicands at WIDTH=8, so isolated zero columns sit between active ones. The bound checker watches the internal column carries and sums on every cycle of that sweep.

// File: rtl/colbyp_mult.sv
module colbyp_mult #(
  parameter int WIDTH   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] p
);
  localparam int PW = 2 * WIDTH;

  // [row][column]; column i is enabled by a[i]
  logic [WIDTH-1:0][WIDTH-1:0] sm;
  logic [WIDTH-1:0][WIDTH-1:0] cy;
  logic [WIDTH-1:0]            rc;
  logic [PW-1:0]               prod;

  genvar j, i, k;

  for (i = 0; i < WIDTH; i++) begin : g_row0
    assign sm[0][i] = a[i] & b[0];
    assign cy[0][i] = 1'b0;
  end

  for (j = 1; j < WIDTH; j++) begin : g_row
    for (i = 0; i < WIDTH; i++) begin : g_cell
      logic s_up, pp, x, y, fs, fc;
      if (i == WIDTH - 1) begin : g_top
        assign s_up = 1'b0;
      end else begin : g_mid
        assign s_up = sm[j-1][i+1];
      end
      assign pp = a[i] & b[j];
      assign x  = s_up & a[i];
      assign y  = cy[j-1][i] & a[i];   // zero on row 1: cell acts as half adder
      assign fs = pp ^ x ^ y;
      assign fc = (pp & x) | (pp & y) | (x & y);
      assign sm[j][i] = a[i] ? fs : s_up;
      assign cy[j][i] = a[i] ? fc : 1'b0;
    end
  end

  assign prod[0] = sm[0][0];
  for (j = 1; j < WIDTH; j++) begin : g_low
    assign prod[j] = sm[j][0];
  end

  assign rc[0] = 1'b0;
  for (k = 0; k < WIDTH; k++) begin : g_merge
    logic mx, my;
    if (k == WIDTH - 1) begin : g_last
      assign mx = 1'b0;
    end else begin : g_body
      assign mx = sm[WIDTH-1][k+1];
      assign rc[k+1] = (mx & my) | (mx & rc[k]) | (my & rc[k]);
    end
    assign my = cy[WIDTH-1][k];
    assign prod[WIDTH+k] = mx ^ my ^ rc[k];
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) p <= '0;
      else     p <= prod;
    end
  end else begin : g_comb
    assign p = prod;
  end
endmodule

// File: rtl/colbyp_mult_chk.sv
module colbyp_mult_chk #(
  parameter int WIDTH   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic                        clk,
  input logic                        rst,
  input logic [WIDTH-1:0]            a,
  input logic [WIDTH-1:0]            b,
  input logic [2*WIDTH-1:0]          p,
  input logic [WIDTH-1:0][WIDTH-1:0] sm,
  input logic [WIDTH-1:0][WIDTH-1:0] cy
);
  localparam int PW = 2 * WIDTH;
  logic vld = 1'b0;
  always_ff @(posedge clk) vld <= !rst;

  if (OUT_REG) begin : g_seq
    p_product_r1: assert property (@(posedge clk) disable iff (rst)
      vld |-> p == ({{WIDTH{1'b0}}, $past(a)} * {{WIDTH{1'b0}}, $past(b)}));
    p_zero_a_r2: assert property (@(posedge clk) disable iff (rst)
      (a == '0) |=> p == '0);
    p_reset_clear_r5: assert property (@(posedge clk)
      rst |=> p == '0);
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      vld && $stable(a) && $stable(b) |=> $stable(p));
  end else begin : g_cmb
    p_product_r1: assert property (@(posedge clk) disable iff (rst)
      p == ({{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b}));
  end

  for (genvar j = 1; j < WIDTH; j++) begin : g_r
    for (genvar i = 0; i < WIDTH; i++) begin : g_c
      p_col_carry_r3: assert property (@(posedge clk) disable iff (rst)
        !a[i] |-> !cy[j][i]);
      if (i == WIDTH - 1) begin : g_t
        p_col_pass_r4: assert property (@(posedge clk) disable iff (rst)
          !a[i] |-> !sm[j][i]);
      end else begin : g_m
        p_col_pass_r4: assert property (@(posedge clk) disable iff (rst)
          !a[i] |-> sm[j][i] == sm[j-1][i+1]);
      end
    end
  end

  logic [PW-1:0] unused_ok;
  assign unused_ok = p;
endmodule

bind colbyp_mult colbyp_mult_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .p(p), .sm(sm), .cy(cy)
);

// File: tb/colbyp_mult_tb.sv
`timescale 1ns/1ps
module colbyp_mult_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a4 = '0, b4 = '0;
  logic [7:0] p4;
  logic [7:0] a8 = '0, b8 = '0;
  logic [15:0] p8;
  int checks = 0;
  int errs = 0;

  always #10 clk = ~clk;

  colbyp_mult #(.WIDTH(4), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .a(a4), .b(b4), .p(p4));
  colbyp_mult #(.WIDTH(8), .OUT_REG(1'b1)) u_dut8 (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .p(p8));

  // {a, b, expected}
  localparam logic [15:0] VEC [0:7] = '{
    {4'b1010, 4'b1111, 8'd150},
    {4'd0,    4'd15,   8'd0},
    {4'd15,   4'd15,   8'd225},
    {4'd5,    4'd10,   8'd50},
    {4'd15,   4'd0,    8'd0},
    {4'd1,    4'd1,    8'd1},
    {4'd9,    4'd7,    8'd63},
    {4'd12,   4'd3,    8'd36}
  };

  task automatic chk4(input logic [7:0] exp, input string tag);
    checks++;
    if (p4 !== exp) begin
      errs++;
      $display("FAIL %s: p=%0d expected %0d (a=%0d b=%0d)", tag, p4, exp, a4, b4);
    end
  endtask

  task automatic chk8(input logic [15:0] exp, input string tag);
    checks++;
    if (p8 !== exp) begin
      errs++;
      $display("FAIL %s: p=%0d expected %0d (a=%0d b=%0d)", tag, p8, exp, a8, b8);
    end
  endtask

  task automatic run4(input logic [3:0] x, input logic [3:0] y);
    @(negedge clk); a4 = x; b4 = y;
    @(negedge clk);
  endtask

  task automatic run8(input logic [7:0] x, input logic [7:0] y);
    @(negedge clk); a8 = x; b8 = y;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    a4 = 4'd15; b4 = 4'd15; a8 = 8'hFF; b8 = 8'hFF;
    repeat (3) @(negedge clk);
    chk4(8'd0, "R5 reset held");
    chk8(16'd0, "R5 reset held w8");
    rst = 1'b0;
    @(negedge clk);

    // table of directed vectors: R9 first row, R2, R7
    for (int n = 0; n < 8; n++) begin
      run4(VEC[n][15:12], VEC[n][11:8]);
      chk4(VEC[n][7:0], "R1/R2/R7/R9 table");
    end

    // exhaustive sweep: every bypass pattern (R1, R3, R4)
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        run4(4'(x), 4'(y));
        chk4(8'(x * y), (x == 0) ? "R2 zero A" : "R1/R3/R4 sweep");
      end
    end

    // latency: new operands must not show before the next edge (R6)
    run4(4'd3, 4'd5);
    a4 = 4'd7; b4 = 4'd7;
    #2;
    chk4(8'd15, "R6 no early change");
    @(negedge clk);
    chk4(8'd49, "R6 update after edge");

    // synchronous reset mid-run (R5)
    run4(4'd15, 4'd15);
    chk4(8'd225, "R7 all ones");
    rst = 1'b1;
    @(negedge clk);
    chk4(8'd0, "R5 reset clears");
    @(negedge clk);
    chk4(8'd0, "R5 reset stays");
    rst = 1'b0;
    @(negedge clk);
    chk4(8'd225, "R5 release");

    // WIDTH=8 (R8)
    run8(8'hFF, 8'hFF);  chk8(16'd65025, "R8 all ones");
    run8(8'hAA, 8'h55);  chk8(16'd14450, "R8 alternating");
    run8(8'h55, 8'hFF);  chk8(16'd21675, "R8 alternating odd");
    run8(8'h00, 8'hC3);  chk8(16'd0,     "R8 zero A");
    run8(8'h81, 8'h81);  chk8(16'd16641, "R8 sparse A");
    for (int n = 0; n < 150; n++) begin
      logic [7:0] x, y;
      x = 8'($urandom);
      y = 8'($urandom);
      run8(x, y);
      chk8(16'({8'd0, x} * {8'd0, y}), "R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule